// File: doc/BRIEF.md
# Monitoring FIFO Queue with Entry Exchange and Rate Windows

This block is a single-clock first-in first-out queue of 16 words of 16 bits. It accepts a push and a pop in the same cycle and drives its fill level on a port every cycle. It raises a level flag while the fill level is at or above a threshold set on an input. The head word is always on the read data port, so a pop takes the word that is shown there.

Two features go beyond a plain queue. The first is an exchange command: it swaps the contents of two stored words, which are named by their distance from the head. The second is a traffic monitor: it counts accepted pushes over a window whose length in cycles is set on an input. When a window closes, the monitor presents the count together with its signed difference from the count of the window before.

Control is built around an occupancy state machine with the states OCC_EMPTY, OCC_PART and OCC_FULL. From OCC_EMPTY, a push moves it to OCC_PART. From OCC_PART, it moves to OCC_FULL when the level reaches 16 and to OCC_EMPTY when the level reaches 0. From OCC_FULL, a pop without a push moves it back to OCC_PART. Every other combination of inputs leaves the state where it is. The state decides which requests are accepted: no pop in OCC_EMPTY, and a push in OCC_FULL only together with a pop.

Top module: `mon_fifo`

## Requirements
- R1: When the level is non-zero, `rd_data` equals the oldest word not yet popped, so words leave in the order they were pushed.
- R2: A push and a pop in the same cycle are both accepted when the queue holds at least one word, including when it is full, and the level stays unchanged. When the queue is empty, only the push takes effect and the level becomes 1.
- R3: `level` gives the number of stored words, from 0 to 16. `full` is high exactly at 16 and `empty` is high exactly at 0. All three are 0/1/0 after reset.
- R4: `lvl_hit` is high in every cycle in which `level` is greater than or equal to `lvl_thresh`.
- R5: When `xchg_en` is high and both `xchg_a` and `xchg_b` are less than `level`, the words at head+`xchg_a` and head+`xchg_b` (0 is the head) trade places from the next cycle on.
- R6: An exchange in which either offset is equal to or greater than `level` leaves every stored word and the level unchanged.
- R7: While `xchg_en` is high, `wr_en` and `rd_en` are ignored, and the level and stored words are changed only by the exchange itself.
- R8: A window lasts `win_len` cycles, and a value of 0 is treated as 1. The first window ends at the `win_len`-th rising edge after reset is released. At each window end, `rate_valid` is high for the following cycle, and `rate_count` shows the pushes accepted during that window, including one accepted at the closing edge. Pushes stalled by an exchange or by a full queue are not counted.
- R9: At each window end, `rate_delta` shows the new count minus the count of the previous window, as a 17-bit two's complement value. The previous count is 0 before the first window.
- R10: A push to a full queue without a pop, and a pop from an empty queue, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | 16 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 16 | Head word |
| level | output | 5 | Number of stored words |
| full | output | 1 | Queue holds 16 words |
| empty | output | 1 | Queue holds no word |
| lvl_thresh | input | 5 | Level threshold |
| lvl_hit | output | 1 | Level at or above threshold |
| xchg_en | input | 1 | Exchange command |
| xchg_a | input | 4 | First offset from head |
| xchg_b | input | 4 | Second offset from head |
| win_len | input | 16 | Window length in cycles |
| rate_count | output | 16 | Pushes counted in the last closed window |
| rate_delta | output | 17 | Signed change from the window before |
| rate_valid | output | 1 | One-cycle pulse at a window end |

## Verification
Several properties are checked on every cycle. The level never exceeds 16 and the two flags are never high together. An exchange cycle leaves the level frozen. A combined push and pop behaves as required at both the full and the empty boundary. A full queue cannot be pushed past, and the window-end pulse lasts a single cycle for windows longer than one cycle. The bench covers what depends on the stored contents, because only a model of the queue can show it: the order in which words leave, the effect of an exchange on that order, rejected exchange offsets, and the window counts and differences as the window length changes.

// File: rtl/mq_pkg.sv
package mq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;
endpackage

// File: rtl/mq_occ_ctrl.sv
module mq_occ_ctrl
    import mq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          xchg_en,
    input  logic [AW-1:0] xchg_a,
    input  logic [AW-1:0] xchg_b,
    output logic          push,
    output logic          pop,
    output logic          xchg_do,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

    occ_e          state_q, state_n;
    logic [LW-1:0] level_q, level_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            level_q <= '0;
        end else begin
            state_q <= state_n;
            level_q <= level_n;
        end
    end

    // accept decisions and next state
    always_comb begin
        push    = 1'b0;
        pop     = 1'b0;
        xchg_do = 1'b0;
        full    = 1'b0;
        empty   = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                empty = 1'b1;
                push  = wr_en && !xchg_en;
            end
            OCC_PART: begin
                push = wr_en && !xchg_en;
                pop  = rd_en && !xchg_en;
            end
            OCC_FULL: begin
                full = 1'b1;
                pop  = rd_en && !xchg_en;
                push = wr_en && rd_en && !xchg_en;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
        xchg_do = xchg_en && ({1'b0, xchg_a} < level_q) && ({1'b0, xchg_b} < level_q);
        level_n = level_q + LW'(push) - LW'(pop);
        if (level_n == '0)
            state_n = OCC_EMPTY;
        else if (level_n == LVL_MAX)
            state_n = OCC_FULL;
        else
            state_n = OCC_PART;
    end

    assign level = level_q;
endmodule

// File: rtl/mq_ring.sv
module mq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          xchg_do,
    input  logic [AW-1:0] xchg_a,
    input  logic [AW-1:0] xchg_b,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] head_q, tail_q;
    logic [AW-1:0] slot_a, slot_b;

    assign slot_a = head_q + xchg_a;
    assign slot_b = head_q + xchg_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (xchg_do) begin
            mem[slot_a] <= mem[slot_b];
            mem[slot_b] <= mem[slot_a];
        end else if (push) begin
            mem[tail_q] <= wr_data;
        end
    end

    assign rd_data = mem[head_q];
endmodule

// File: rtl/mq_rate_mon.sv
module mq_rate_mon #(
    parameter int CW = 16,
    parameter int WW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [WW-1:0]        win_len,
    output logic [CW-1:0]        rate_count,
    output logic signed [CW:0]   rate_delta,
    output logic                 rate_valid
);
    logic [WW-1:0] tick_q;
    logic [CW-1:0] cnt_q, prev_q, cur;
    logic [WW-1:0] last_tick;
    logic          win_end;

    assign last_tick = (win_len == '0) ? '0 : win_len - 1'b1;
    assign win_end   = (tick_q >= last_tick);
    assign cur       = cnt_q + CW'(push);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q     <= '0;
            cnt_q      <= '0;
            prev_q     <= '0;
            rate_count <= '0;
            rate_delta <= '0;
            rate_valid <= 1'b0;
        end else if (win_end) begin
            tick_q     <= '0;
            cnt_q      <= '0;
            prev_q     <= cur;
            rate_count <= cur;
            rate_delta <= $signed({1'b0, cur}) - $signed({1'b0, prev_q});
            rate_valid <= 1'b1;
        end else begin
            tick_q     <= tick_q + 1'b1;
            cnt_q      <= cur;
            rate_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/mon_fifo.sv
module mon_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int WW    = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    output logic [DW-1:0]       rd_data,
    output logic [LW-1:0]       level,
    output logic                full,
    output logic                empty,
    input  logic [LW-1:0]       lvl_thresh,
    output logic                lvl_hit,
    input  logic                xchg_en,
    input  logic [AW-1:0]       xchg_a,
    input  logic [AW-1:0]       xchg_b,
    input  logic [WW-1:0]       win_len,
    output logic [CW-1:0]       rate_count,
    output logic signed [CW:0]  rate_delta,
    output logic                rate_valid
);
    logic push, pop, xchg_do;

    mq_occ_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .xchg_en(xchg_en), .xchg_a(xchg_a), .xchg_b(xchg_b),
        .push(push), .pop(pop), .xchg_do(xchg_do),
        .level(level), .full(full), .empty(empty)
    );

    mq_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .xchg_do(xchg_do), .xchg_a(xchg_a), .xchg_b(xchg_b),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    mq_rate_mon #(.CW(CW), .WW(WW)) u_rate (
        .clk(clk), .rst_n(rst_n), .push(push), .win_len(win_len),
        .rate_count(rate_count), .rate_delta(rate_delta), .rate_valid(rate_valid)
    );

    assign lvl_hit = (level >= lvl_thresh);
endmodule

// File: rtl/mon_fifo_chk.sv
module mon_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5,
    parameter int WW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          xchg_en,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          rate_valid,
    input logic [WW-1:0] win_len
);
    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7
    xchg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_en |=> $stable(level));

    // R2
    full_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en && !xchg_en) |=> full);

    // R2
    empty_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en && rd_en && !xchg_en) |=> (level == LW'(1)));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && win_len > WW'(1)) |=> !rate_valid);
endmodule

bind mon_fifo mon_fifo_chk #(.DEPTH(DEPTH), .LW(LW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .xchg_en(xchg_en), .level(level), .full(full), .empty(empty),
    .rate_valid(rate_valid), .win_len(win_len)
);

// File: tb/sim_mon_fifo.sv
`timescale 1ns/1ps
module sim_mon_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [4:0]  level;
    logic        full, empty;
    logic [4:0]  lvl_thresh = 5'd8;
    logic        lvl_hit;
    logic        xchg_en = 1'b0;
    logic [3:0]  xchg_a = '0, xchg_b = '0;
    logic [15:0] win_len = 16'd10;
    logic [15:0] rate_count;
    logic signed [16:0] rate_delta;
    logic        rate_valid;

    int tests = 0;
    int fails = 0;

    // reference state
    logic [15:0] mq [16];
    int md = 0;
    int m_tick = 0, m_cnt = 0, m_prev = 0, m_rate = 0, m_delta = 0;
    bit m_valid = 0;

    always #2 clk = ~clk;

    mon_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .level(level), .full(full),
        .empty(empty), .lvl_thresh(lvl_thresh), .lvl_hit(lvl_hit),
        .xchg_en(xchg_en), .xchg_a(xchg_a), .xchg_b(xchg_b),
        .win_len(win_len), .rate_count(rate_count), .rate_delta(rate_delta),
        .rate_valid(rate_valid)
    );

    function automatic bit exp_hit(int d, int t);
        return d >= t;
    endfunction

    function automatic int exp_last(int w);
        return (w == 0) ? 0 : w - 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // advance one cycle, update model from the inputs, compare outputs
    task automatic step();
        bit p, q, x;
        logic [15:0] t;
        @(posedge clk);
        x = xchg_en;
        q = rd_en && !x && md > 0;
        p = wr_en && !x && (md < 16 || q);
        if (x && xchg_a < md && xchg_b < md) begin
            t = mq[xchg_a]; mq[xchg_a] = mq[xchg_b]; mq[xchg_b] = t;
        end
        if (q) begin
            for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
            md--;
        end
        if (p) begin
            mq[md] = wr_data;
            md++;
        end
        if (m_tick >= exp_last(win_len)) begin
            m_rate  = m_cnt + p;
            m_delta = m_rate - m_prev;
            m_prev  = m_rate;
            m_cnt   = 0;
            m_tick  = 0;
            m_valid = 1;
        end else begin
            m_cnt  = m_cnt + p;
            m_tick = m_tick + 1;
            m_valid = 0;
        end
        @(negedge clk);
        chk(level == md, "R3 level", level, md);
        chk(full == (md == 16) && empty == (md == 0), "R3 flags", {full, empty}, {md == 16, md == 0});
        chk(lvl_hit == exp_hit(md, lvl_thresh), "R4 lvl_hit", lvl_hit, exp_hit(md, lvl_thresh));
        if (md > 0) chk(rd_data == mq[0], "R1 head", rd_data, mq[0]);
        chk(rate_valid == m_valid, "R8 rate_valid", rate_valid, m_valid);
        if (m_valid) begin
            chk(rate_count == m_rate, "R8 rate_count", rate_count, m_rate);
            chk(rate_delta == m_delta, "R9 rate_delta", rate_delta, m_delta);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; xchg_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(level == 0 && empty && !full, "R3 reset", level, 0);
        chk(rate_valid == 0, "R8 reset", rate_valid, 0);

        // fill to full, one more push dropped (R10)
        for (int i = 0; i < 17; i++) begin
            wr_en = 1; wr_data = 16'h100 + 16'(i); step();
        end
        chk(level == 16 && full, "R10 push on full dropped", level, 16);
        // push and pop together while full (R2)
        wr_data = 16'hBEEF; rd_en = 1; step();
        chk(level == 16 && rd_data == 16'h101, "R2 full rd+wr", rd_data, 16'h101);
        idle();
        // exchange offsets 0 and 15 (R5)
        xchg_en = 1; xchg_a = 0; xchg_b = 15; step();
        chk(rd_data == 16'hBEEF, "R5 exchange head/tail", rd_data, 16'hBEEF);
        // exchange with push and pop requested: stalled (R7)
        wr_en = 1; rd_en = 1; xchg_a = 1; xchg_b = 2; step();
        chk(level == 16 && rd_data == 16'hBEEF, "R7 ports stalled", level, 16);
        idle();
        // drain to empty, then pop on empty (R10)
        for (int i = 0; i < 17; i++) begin rd_en = 1; step(); end
        chk(level == 0 && empty, "R10 pop on empty ignored", level, 0);
        // push and pop on empty: only push (R2)
        wr_en = 1; rd_en = 1; wr_data = 16'h55AA; step();
        chk(level == 1 && rd_data == 16'h55AA, "R2 empty rd+wr", level, 1);
        idle();
        wr_en = 1; wr_data = 16'h0777; step(); idle();
        // offset at level rejected (R6)
        xchg_en = 1; xchg_a = 0; xchg_b = 2; step(); idle();
        chk(rd_data == 16'h55AA && level == 2, "R6 out-of-range exchange", rd_data, 16'h55AA);
        // zero window length behaves as one (R8)
        win_len = 0; step(); step();
        chk(rate_valid == 1, "R8 zero length window", rate_valid, 1);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                win_len = 16'($urandom_range(0, 25));
                lvl_thresh = 5'($urandom_range(0, 17));
            end
            xchg_en = ($urandom_range(0, 9) == 0);
            xchg_a  = 4'($urandom_range(0, 15));
            xchg_b  = 4'($urandom_range(0, 15));
            wr_en   = ($urandom_range(0, 99) < ((n / 250) % 2 ? 70 : 35));
            rd_en   = ($urandom_range(0, 99) < 50);
            wr_data = 16'($urandom);
            step();
        end
        idle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule